// File: doc/BRIEF.md
# Low-Order Path Overhead Byte Monitor

This block checks the overhead byte that opens each low-order tributary multiframe on the receive side. Bytes arrive one per strobe on a byte-wide bus. One strobe marks the overhead byte. A second strobe marks each payload byte. Over each multiframe the block builds a two-bit interleaved parity. When the next overhead byte arrives, it compares that parity with the two parity bits the byte carries. Parity errors are counted either per bit or per block, as a mode input selects. Far-end error indications are counted as well.

Three fields of the overhead byte pass through a persistence filter before they are reported. These are the remote defect bit, the remote failure bit and the three-bit signal label. A field value is accepted only once it has arrived in a set number of consecutive multiframes. The accepted label is classified as unequipped, alarm-indication, or mismatched against a provisioned expected label. Any of these three classes raises a request for downstream alarm insertion, and an inhibit input can suppress that request. A latch strobe copies both saturating counters into holding registers and restarts them.

Top module: `lo_poh_mon`

## Requirements
- R1: Parity bit 7 of the overhead byte is checked against the even parity of bits 7, 5, 3 and 1 of every byte in the previous multiframe. Parity bit 6 is checked against the even parity of bits 6, 4, 2 and 0 of the same bytes. The previous multiframe runs from the previous overhead byte, included, through the last payload byte before the current one. The first overhead byte after reset is not checked.
- R2: With `bit_mode` high, each overhead byte adds the number of mismatching parity bits (0, 1 or 2) to the parity error counter.
- R3: With `bit_mode` low, each overhead byte adds at most one to the parity error counter, and adds one when either parity bit mismatches.
- R4: Each overhead byte whose bit 5 (far-end error) is 1 adds one to the far-end error counter.
- R5: Both counters saturate at all-ones and never wrap.
- R6: On `cnt_latch`, each holding register takes its counter's value, and the counter restarts from zero plus any increment arriving in the same cycle. The holding registers change at no other time and read zero after reset.
- R7: The remote defect flag takes the value of bit 0 once that value has arrived in PERSIST consecutive overhead bytes. It clears the same way.
- R8: The remote failure flag takes the value of bit 4 under the same PERSIST-consecutive rule.
- R9: The accepted label takes bits 3:1 once the same value has arrived in PERSIST consecutive overhead bytes. `label_chg` pulses for one cycle when the accepted label changes.
- R10: Accepted label 000 raises `unequipped`. Accepted label 111 raises `vt_ais_label`. Any other accepted label that differs from `exp_label` raises `label_mismatch`. After reset the accepted label is 000.
- R11: `ais_req` is high when any of `unequipped`, `vt_ais_label` or `label_mismatch` is high and `ais_inhibit` is low. `ais_inhibit` takes effect in the same cycle.
- R12: Flags, the accepted label and the counters change only at an overhead strobe (counters also at a latch). Each such change is visible in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| v5_stb | input | 1 | Marks `rx_byte` as the overhead byte |
| pay_stb | input | 1 | Marks `rx_byte` as a payload byte |
| rx_byte | input | 8 | Received byte, bit 7 sent first |
| bit_mode | input | 1 | 1: count per bit, 0: count per block |
| exp_label | input | 3 | Expected signal label |
| ais_inhibit | input | 1 | Suppresses `ais_req` |
| cnt_latch | input | 1 | Copies the counters to the holding registers and clears them |
| bip_err_hold | output | CNT_W | Latched parity error count |
| rei_hold | output | CNT_W | Latched far-end error count |
| rdi_flag | output | 1 | Filtered remote defect |
| rfi_flag | output | 1 | Filtered remote failure |
| label_acc | output | 3 | Accepted signal label |
| label_chg | output | 1 | One-cycle pulse when the accepted label changes |
| unequipped | output | 1 | Accepted label is 000 |
| vt_ais_label | output | 1 | Accepted label is 111 |
| label_mismatch | output | 1 | Accepted label differs from the expected one |
| ais_req | output | 1 | Downstream alarm insertion request |

## Verification
The bench builds the block with CNT_W = 4 and PERSIST = 3, so a counter saturates at 15 after a few errored multiframes. With a persistence of three, runs that fall short of acceptance or just reach it occur often. A long sweep applies every parity error pattern under both counting modes and every expected label. It uses field runs of one to six multiframes and payload lengths including zero, with latches both alone and coinciding with an overhead byte. A mid-run reset shows that the first overhead byte afterwards is not checked. A saturation burst drives both counters to all-ones.

// File: rtl/lo_poh_pkg.sv
package lo_poh_pkg;

   localparam int OH_W = 8;

   typedef struct packed {
      logic [1:0] bip;
      logic       rei;
      logic       rfi;
      logic [2:0] label;
      logic       rdi;
   } oh_byte_t;

   localparam logic [2:0] LBL_UNEQ = 3'b000;
   localparam logic [2:0] LBL_AIS  = 3'b111;

   function automatic logic [1:0] bip2_of(input logic [OH_W-1:0] b);
      return {^(b & 8'hAA), ^(b & 8'h55)};
   endfunction

endpackage

// File: rtl/poh_bip2_check.sv
module poh_bip2_check
   import lo_poh_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            v5_stb,
   input  logic            pay_stb,
   input  logic [OH_W-1:0] rx_byte,
   input  logic            bit_mode,
   output logic [1:0]      err_inc
);
   logic [1:0] par_acc;
   logic       have_prev;
   logic [1:0] mism;

   // R1: accumulated parity of the multiframe that ends at this overhead byte
   assign mism = rx_byte[7:6] ^ par_acc;

   always_comb begin
      err_inc = 2'd0;
      if (v5_stb && have_prev) begin
         if (bit_mode) err_inc = {1'b0, mism[1]} + {1'b0, mism[0]};
         else          err_inc = {1'b0, |mism};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_acc   <= 2'b00;
         have_prev <= 1'b0;
      end else if (v5_stb) begin
         par_acc   <= bip2_of(rx_byte);
         have_prev <= 1'b1;
      end else if (pay_stb) begin
         par_acc   <= par_acc ^ bip2_of(rx_byte);
      end
   end
endmodule

// File: rtl/poh_sat_counter.sv
module poh_sat_counter #(
   parameter int CNT_W = 8,
   parameter int INC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc,
   input  logic             latch,
   output logic [CNT_W-1:0] live,
   output logic [CNT_W-1:0] hold
);
   localparam int SUM_W = CNT_W + 1;

   generate
      if (INC_W >= CNT_W) begin : g_bad
         $error("poh_sat_counter: INC_W must be narrower than CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] base;
   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] nxt;

   assign base = latch ? '0 : live;
   assign sum  = {1'b0, base} + SUM_W'(inc);
   assign nxt  = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live <= '0;
         hold <= '0;
      end else begin
         live <= nxt;
         if (latch) hold <= live;
      end
   end
endmodule

// File: rtl/poh_persist.sv
module poh_persist #(
   parameter int W     = 1,
   parameter int DEPTH = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb,
   input  logic [W-1:0] val,
   output logic [W-1:0] acc,
   output logic         chg
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0] acc_nx;

   generate
      if (DEPTH < 1) begin : g_bad
         $error("poh_persist: DEPTH must be at least 1");
      end else if (DEPTH == 1) begin : g_direct
         assign acc_nx = stb ? val : acc;
      end else begin : g_filter
         logic [W-1:0]  cand;
         logic [CW-1:0] run;

         assign acc_nx = (stb && val == cand && run >= CW'(DEPTH - 1)) ? val : acc;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cand <= '0;
               run  <= '0;
            end else if (stb) begin
               if (val == cand) begin
                  if (run != CW'(DEPTH)) run <= run + 1'b1;
               end else begin
                  cand <= val;
                  run  <= CW'(1);
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
         chg <= 1'b0;
      end else begin
         acc <= acc_nx;
         chg <= (acc_nx != acc);
      end
   end
endmodule

// File: rtl/lo_poh_mon.sv
module lo_poh_mon
   import lo_poh_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int PERSIST = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v5_stb,
   input  logic             pay_stb,
   input  logic [7:0]       rx_byte,
   input  logic             bit_mode,
   input  logic [2:0]       exp_label,
   input  logic             ais_inhibit,
   input  logic             cnt_latch,
   output logic [CNT_W-1:0] bip_err_hold,
   output logic [CNT_W-1:0] rei_hold,
   output logic             rdi_flag,
   output logic             rfi_flag,
   output logic [2:0]       label_acc,
   output logic             label_chg,
   output logic             unequipped,
   output logic             vt_ais_label,
   output logic             label_mismatch,
   output logic             ais_req
);
   localparam int INC_W = 2;

   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("lo_poh_mon: CNT_W must be at least 3");
      end
      if (PERSIST < 1) begin : g_bad_persist
         $error("lo_poh_mon: PERSIST must be at least 1");
      end
   endgenerate

   oh_byte_t         oh;
   logic [1:0]       bip_inc;
   logic [1:0]       rei_inc;
   logic [CNT_W-1:0] bip_live;
   logic [CNT_W-1:0] rei_live;
   logic             rdi_chg;
   logic             rfi_chg;

   assign oh      = oh_byte_t'(rx_byte);
   assign rei_inc = {1'b0, v5_stb & oh.rei};

   poh_bip2_check u_bip (
      .clk(clk), .rst_n(rst_n), .v5_stb(v5_stb), .pay_stb(pay_stb),
      .rx_byte(rx_byte), .bit_mode(bit_mode), .err_inc(bip_inc)
   );

   poh_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_bip_cnt (
      .clk(clk), .rst_n(rst_n), .inc(bip_inc), .latch(cnt_latch),
      .live(bip_live), .hold(bip_err_hold)
   );

   poh_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_rei_cnt (
      .clk(clk), .rst_n(rst_n), .inc(rei_inc), .latch(cnt_latch),
      .live(rei_live), .hold(rei_hold)
   );

   poh_persist #(.W(1), .DEPTH(PERSIST)) u_rdi (
      .clk(clk), .rst_n(rst_n), .stb(v5_stb), .val(oh.rdi),
      .acc(rdi_flag), .chg(rdi_chg)
   );

   poh_persist #(.W(1), .DEPTH(PERSIST)) u_rfi (
      .clk(clk), .rst_n(rst_n), .stb(v5_stb), .val(oh.rfi),
      .acc(rfi_flag), .chg(rfi_chg)
   );

   poh_persist #(.W(3), .DEPTH(PERSIST)) u_lbl (
      .clk(clk), .rst_n(rst_n), .stb(v5_stb), .val(oh.label),
      .acc(label_acc), .chg(label_chg)
   );

   assign unequipped     = (label_acc == LBL_UNEQ);
   assign vt_ais_label   = (label_acc == LBL_AIS);
   assign label_mismatch = !unequipped && !vt_ais_label && (label_acc != exp_label);
   assign ais_req        = !ais_inhibit && (unequipped || vt_ais_label || label_mismatch);

   logic unused_chg;
   assign unused_chg = rdi_chg ^ rfi_chg ^ (|rei_live);
endmodule

// File: rtl/lo_poh_mon_chk.sv
module lo_poh_mon_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             v5_stb,
   input logic             cnt_latch,
   input logic             ais_inhibit,
   input logic             ais_req,
   input logic             unequipped,
   input logic             vt_ais_label,
   input logic             label_mismatch,
   input logic             label_chg,
   input logic             rdi_flag,
   input logic             rfi_flag,
   input logic [2:0]       label_acc,
   input logic [CNT_W-1:0] bip_err_hold,
   input logic [CNT_W-1:0] rei_hold,
   input logic [CNT_W-1:0] bip_live
);
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (bip_live == '1 && !cnt_latch) |=> (bip_live == '1)); // R5

   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_latch |=> ($stable(bip_err_hold) && $stable(rei_hold))); // R6

   AST_HOLD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_latch |=> (bip_err_hold == $past(bip_live))); // R6

   AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!v5_stb && !cnt_latch) |=> $stable(bip_live)); // R1

   AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !v5_stb |=> ($stable(rdi_flag) && $stable(rfi_flag) && $stable(label_acc))); // R12

   AST_CHG_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
      label_chg |-> $past(v5_stb)); // R9

   AST_LABEL_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({unequipped, vt_ais_label, label_mismatch})); // R10

   AST_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
      ais_inhibit |-> !ais_req); // R11
endmodule

bind lo_poh_mon lo_poh_mon_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .v5_stb(v5_stb), .cnt_latch(cnt_latch),
   .ais_inhibit(ais_inhibit), .ais_req(ais_req), .unequipped(unequipped),
   .vt_ais_label(vt_ais_label), .label_mismatch(label_mismatch),
   .label_chg(label_chg), .rdi_flag(rdi_flag), .rfi_flag(rfi_flag),
   .label_acc(label_acc), .bip_err_hold(bip_err_hold), .rei_hold(rei_hold),
   .bip_live(bip_live)
);

// File: tb/lo_poh_mon_test.sv
`timescale 1ns/1ps
module lo_poh_mon_test;
   localparam int CW   = 4;
   localparam int PD   = 3;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          v5_stb = 1'b0, pay_stb = 1'b0, bit_mode = 1'b0;
   logic [7:0]    rx_byte = 8'h00;
   logic [2:0]    exp_label = 3'd0;
   logic          ais_inhibit = 1'b0, cnt_latch = 1'b0;
   logic [CW-1:0] bip_err_hold, rei_hold;
   logic          rdi_flag, rfi_flag, label_chg, unequipped, vt_ais_label;
   logic          label_mismatch, ais_req;
   logic [2:0]    label_acc;

   lo_poh_mon #(.CNT_W(CW), .PERSIST(PD)) uut (
      .clk(clk), .rst_n(rst_n), .v5_stb(v5_stb), .pay_stb(pay_stb),
      .rx_byte(rx_byte), .bit_mode(bit_mode), .exp_label(exp_label),
      .ais_inhibit(ais_inhibit), .cnt_latch(cnt_latch),
      .bip_err_hold(bip_err_hold), .rei_hold(rei_hold),
      .rdi_flag(rdi_flag), .rfi_flag(rfi_flag), .label_acc(label_acc),
      .label_chg(label_chg), .unequipped(unequipped),
      .vt_ais_label(vt_ais_label), .label_mismatch(label_mismatch),
      .ais_req(ais_req)
   );

   int nvec = 0, nfail = 0;
   int unsigned st = 32'h1234_5677;

   // model state
   logic [1:0] m_par;
   bit         m_valid;
   int         m_bip, m_rei;
   int         p_last [3], p_run [3], p_acc [3];

   function automatic int unsigned rnd();
      st ^= st << 13; st ^= st >> 17; st ^= st << 5;
      return st;
   endfunction

   function automatic logic [1:0] par_of(input logic [7:0] b);
      return {b[7] ^ b[5] ^ b[3] ^ b[1], b[6] ^ b[4] ^ b[2] ^ b[0]};
   endfunction

   function automatic int sat(input int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_par = 2'b00; m_valid = 0; m_bip = 0; m_rei = 0;
      for (int i = 0; i < 3; i++) begin
         p_last[i] = 0; p_run[i] = 0; p_acc[i] = 0;
      end
   endtask

   task automatic pers_upd(input int i, input int v);
      if (v == p_last[i]) p_run[i]++;
      else begin p_last[i] = v; p_run[i] = 1; end
      if (p_run[i] >= PD) p_acc[i] = v;
   endtask

   task automatic check_flags(input int exp_chg);
      int  lbl;
      bit  e_un, e_ais, e_mis, e_req;
      lbl   = p_acc[2];
      e_un  = (lbl == 0);
      e_ais = (lbl == 7);
      e_mis = !e_un && !e_ais && (lbl != int'(exp_label));
      chk("R7", "rdi_flag", int'(rdi_flag), p_acc[0]);
      chk("R8", "rfi_flag", int'(rfi_flag), p_acc[1]);
      chk("R9", "label_acc", int'(label_acc), lbl);
      chk("R9", "label_chg", int'(label_chg), exp_chg);
      chk("R10", "unequipped", int'(unequipped), int'(e_un));
      chk("R10", "vt_ais_label", int'(vt_ais_label), int'(e_ais));
      chk("R10", "label_mismatch", int'(label_mismatch), int'(e_mis));
      e_req = (e_un || e_ais || e_mis);
      chk("R11", "ais_req", int'(ais_req), int'(e_req && !ais_inhibit));
      ais_inhibit = ~ais_inhibit;
      #1;
      chk("R11", "ais_req flipped", int'(ais_req), int'(e_req && !ais_inhibit));
      ais_inhibit = ~ais_inhibit;
      #1;
   endtask

   task automatic send_pay(input logic [7:0] b);
      @(negedge clk);
      pay_stb = 1'b1; rx_byte = b;
      @(negedge clk);
      pay_stb = 1'b0;
      m_par ^= par_of(b);
   endtask

   task automatic send_oh(input logic [1:0] err, input bit rei, input bit rfi,
                          input logic [2:0] lbl, input bit rdi, input bit latch);
      logic [7:0] v;
      logic [1:0] mm;
      int inc, old_lbl;
      v = {m_par ^ err, rei, rfi, lbl, rdi};
      @(negedge clk);
      v5_stb = 1'b1; cnt_latch = latch; rx_byte = v;
      @(negedge clk);
      v5_stb = 1'b0; cnt_latch = 1'b0;
      // R1: compare against parity of the previous multiframe
      inc = 0;
      if (m_valid) begin
         mm  = v[7:6] ^ m_par;
         inc = bit_mode ? (int'(mm[1]) + int'(mm[0])) : int'(|mm);
      end
      if (latch) begin
         chk(bit_mode ? "R2" : "R3", "bip hold with strobe", int'(bip_err_hold), m_bip);
         chk("R4", "rei hold with strobe", int'(rei_hold), m_rei);
         m_bip = sat(inc); m_rei = sat(int'(rei));
      end else begin
         m_bip = sat(m_bip + inc); m_rei = sat(m_rei + int'(rei));
      end
      m_par   = par_of(v);
      m_valid = 1;
      old_lbl = p_acc[2];
      pers_upd(0, int'(rdi));
      pers_upd(1, int'(rfi));
      pers_upd(2, int'(lbl));
      check_flags(int'(old_lbl != p_acc[2]));
   endtask

   task automatic do_latch(input string req);
      @(negedge clk);
      cnt_latch = 1'b1;
      @(negedge clk);
      cnt_latch = 1'b0;
      chk(req, "bip_err_hold", int'(bip_err_hold), m_bip);
      chk((req == "R5") ? "R5" : "R4", "rei_hold", int'(rei_hold), m_rei);
      m_bip = 0; m_rei = 0;
   endtask

   initial begin
      #(64'd20 * 64'd200000);
      nfail++;
      $display("FAIL R12 watchdog: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      int rdi_run, rfi_run, lbl_run;
      bit rdi_v, rfi_v;
      logic [2:0] lbl_v;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6", "bip hold reset", int'(bip_err_hold), 0);
      chk("R6", "rei hold reset", int'(rei_hold), 0);
      check_flags(0);

      // sweep: error patterns, both modes, expected labels, run lengths
      rdi_run = 0; rfi_run = 0; lbl_run = 0;
      rdi_v = 0; rfi_v = 0; lbl_v = 3'd0;
      for (int mf = 0; mf < 640; mf++) begin
         bit_mode    = ((mf / 40) % 2) == 1;
         exp_label   = 3'((mf / 20) % 8);
         ais_inhibit = ((mf / 9) % 2) == 1;
         for (int k = 0; k < int'(rnd() % 4); k++) send_pay(8'(rnd()));
         if (rdi_run == 0) begin rdi_v = ~rdi_v; rdi_run = 1 + int'(rnd() % 6); end
         if (rfi_run == 0) begin rfi_v = ~rfi_v; rfi_run = 1 + int'(rnd() % 6); end
         if (lbl_run == 0) begin lbl_v = 3'(rnd()); lbl_run = 1 + int'(rnd() % 6); end
         rdi_run--; rfi_run--; lbl_run--;
         send_oh(2'(mf % 4), rnd() % 2 == 1, rfi_v, lbl_v, rdi_v, (mf % 11) == 5);
         if ((mf % 11) == 10) do_latch(bit_mode ? "R2" : "R3");
      end
      do_latch(bit_mode ? "R2" : "R3");

      // saturation burst
      bit_mode = 1'b1;
      for (int mf = 0; mf < 20; mf++) begin
         send_pay(8'(rnd()));
         send_oh(2'b11, 1'b1, 1'b0, 3'd5, 1'b0, 1'b0);
      end
      send_pay(8'h3C);
      check_flags(0); // R12: payload byte leaves flags alone
      do_latch("R5");
      do_latch("R5");

      // R1: first overhead byte after reset is not checked
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      send_pay(8'hF0);
      send_oh(2'b11, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0);
      do_latch("R1");
      send_pay(8'h81);
      send_oh(2'b10, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0);
      do_latch("R1");

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule